// File: doc/BRIEF.md
# Software-Refilled Address Translation Cache

This block is a fully associative translation cache for a paged memory system. Each slot maps one virtual page to one physical frame for one process, tagged with a process identifier. A lookup compares the virtual page number and the current process identifier against every slot at once. The response arrives in the cycle after the request and carries either the frame number or an exception flag.

The cache never reads page tables on its own. When a lookup misses, the miss flag tells the surrounding core to trap. System software then finds the mapping, writes it into a slot of its choosing through the indexed write port, and the faulting access is retried. Software can inspect any slot through the probe port, and a single strobe drops every mapping at once, for example on an address space switch when identifiers run out.

A slot is loaded as two 32-bit words. The upper word carries the virtual page number in bits 31:12 and the process identifier in bits 11:6. The lower word carries the frame number in bits 31:12, the write-permission bit in bit 10 and the valid bit in bit 9. All other bits are ignored on write and read back as zero.

Top module: `tlb_sw_top`

## Requirements
- R1: After reset every slot is invalid with all fields zero, and all response outputs are low. A lookup for page 0 with identifier 0 then misses.
- R2: A write to slot `wr_idx` stores the upper-word page number (bits 31:12) and identifier (bits 11:6), and the lower-word frame (bits 31:12), write-permission (bit 10) and valid (bit 9). A probe of that slot returns these fields in the same positions one cycle later, with every other bit zero.
- R3: A lookup hits only when a slot is valid and both its page number and its identifier equal the request. The hit is reported on `rsp_hit` together with that slot's frame in the cycle after the request.
- R4: A lookup that matches no slot raises `rsp_miss_exc`, with `rsp_hit` low and `rsp_frame` zero.
- R5: A write lookup that hits a slot whose write-permission bit is clear raises `rsp_wprot_exc` while still reporting the hit and frame. A read lookup of the same slot raises nothing.
- R6: When more than one slot matches, the frame of the lowest-index matching slot is returned and `rsp_multi` is raised.
- R7: `inval_all` clears every valid bit in one cycle and leaves the other fields unchanged. Lookups made afterwards miss, and probes show valid as 0.
- R8: When `inval_all` and `wr_en` are high in the same cycle, the write is discarded: the addressed slot keeps its old fields and ends invalid.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `lk_req` high. In every other cycle, `rsp_hit`, `rsp_miss_exc`, `rsp_wprot_exc`, `rsp_multi` and `rsp_frame` are zero.
- R10: Rewriting a slot replaces all of its fields, so a lookup for the old key no longer matches that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_pid | input | 6 | Current process identifier |
| lk_write | input | 1 | Access is a store |
| rsp_valid | output | 1 | Response present (cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_frame | output | 20 | Frame number on hit, else zero |
| rsp_miss_exc | output | 1 | Miss exception |
| rsp_wprot_exc | output | 1 | Store to a write-protected page |
| rsp_multi | output | 1 | Two or more slots matched |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 6 | Slot index to write |
| wr_hi | input | 32 | Upper word: page number, identifier |
| wr_lo | input | 32 | Lower word: frame, write permission, valid |
| rd_idx | input | 6 | Slot index to probe |
| rd_hi | output | 32 | Probed upper word (one cycle later) |
| rd_lo | output | 32 | Probed lower word (one cycle later) |
| inval_all | input | 1 | Invalidate every slot |

## Verification
The bench builds the block with its default parameters: 64 slots, 20-bit page and frame numbers and 6-bit identifiers. With these values the whole index space is reachable, including the top slot 63. The random phase draws page numbers from eight values and identifiers from four, so duplicate keys in separate slots and identifier-only mismatches occur often. This exercises multi-match priority and identifier tagging far more than fully random keys would.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_SLOTS  = 64;
  localparam int TLB_WORD_W = 32;
  localparam int TLB_VPN_W  = 20;
  localparam int TLB_PID_W  = 6;
  localparam int TLB_PFN_W  = 20;
  localparam int TLB_WP_BIT = 10;
  localparam int TLB_V_BIT  = 9;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tlb_slot_store.sv
module tlb_slot_store #(
  parameter int SLOTS = 64,
  parameter int VPN_W = 20,
  parameter int PID_W = 6,
  parameter int PFN_W = 20,
  parameter int IDX_W = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [VPN_W-1:0]             wr_vpn,
  input  logic [PID_W-1:0]             wr_pid,
  input  logic [PFN_W-1:0]             wr_pfn,
  input  logic                         wr_wp,
  input  logic                         wr_valid,
  input  logic                         inval_all,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [SLOTS-1:0][VPN_W-1:0]  vpn_q,
  output logic [SLOTS-1:0][PID_W-1:0]  pid_q,
  output logic [SLOTS-1:0][PFN_W-1:0]  pfn_q,
  output logic [SLOTS-1:0]             wp_q,
  output logic [SLOTS-1:0]             valid_q,
  output logic [VPN_W-1:0]             rd_vpn,
  output logic [PID_W-1:0]             rd_pid,
  output logic [PFN_W-1:0]             rd_pfn,
  output logic                         rd_wp,
  output logic                         rd_valid
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && !inval_all && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        vpn_q[g]   <= '0;
        pid_q[g]   <= '0;
        pfn_q[g]   <= '0;
        wp_q[g]    <= 1'b0;
        valid_q[g] <= 1'b0;
      end else if (inval_all) begin
        valid_q[g] <= 1'b0;
      end else if (sel) begin
        vpn_q[g]   <= wr_vpn;
        pid_q[g]   <= wr_pid;
        pfn_q[g]   <= wr_pfn;
        wp_q[g]    <= wr_wp;
        valid_q[g] <= wr_valid;
      end
    end
  end

  logic rd_in_range;
  assign rd_in_range = (int'(rd_idx) < SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vpn   <= '0;
      rd_pid   <= '0;
      rd_pfn   <= '0;
      rd_wp    <= 1'b0;
      rd_valid <= 1'b0;
    end else if (rd_in_range) begin
      rd_vpn   <= vpn_q[rd_idx];
      rd_pid   <= pid_q[rd_idx];
      rd_pfn   <= pfn_q[rd_idx];
      rd_wp    <= wp_q[rd_idx];
      rd_valid <= valid_q[rd_idx];
    end else begin
      rd_vpn   <= '0;
      rd_pid   <= '0;
      rd_pfn   <= '0;
      rd_wp    <= 1'b0;
      rd_valid <= 1'b0;
    end
  end

  // R7
  inval_clears_chk: assert property (@(posedge clk) disable iff (rst)
    inval_all |=> (valid_q == '0));

  // R8
  inval_beats_write_chk: assert property (@(posedge clk) disable iff (rst)
    (inval_all && wr_en) |=> $stable(vpn_q) && $stable(pfn_q));

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int SLOTS = 64,
  parameter int VPN_W = 20,
  parameter int PID_W = 6,
  parameter int PFN_W = 20
) (
  input  logic [SLOTS-1:0][VPN_W-1:0] vpn_q,
  input  logic [SLOTS-1:0][PID_W-1:0] pid_q,
  input  logic [SLOTS-1:0][PFN_W-1:0] pfn_q,
  input  logic [SLOTS-1:0]            wp_q,
  input  logic [SLOTS-1:0]            valid_q,
  input  logic [VPN_W-1:0]            key_vpn,
  input  logic [PID_W-1:0]            key_pid,
  output logic                        any_hit,
  output logic                        multi_hit,
  output logic [PFN_W-1:0]            hit_pfn,
  output logic                        hit_wp
);

  logic [SLOTS-1:0] match;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == key_vpn) && (pid_q[g] == key_pid);
  end

  always_comb begin
    any_hit   = 1'b0;
    multi_hit = 1'b0;
    hit_pfn   = '0;
    hit_wp    = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (match[i]) begin
        if (any_hit) begin
          multi_hit = 1'b1;
        end else begin
          any_hit = 1'b1;
          hit_pfn = pfn_q[i];
          hit_wp  = wp_q[i];
        end
      end
    end
  end

endmodule

// File: rtl/tlb_sw_top.sv
module tlb_sw_top
  import tlb_pkg::*;
#(
  parameter int SLOTS  = TLB_SLOTS,
  parameter int WORD_W = TLB_WORD_W,
  parameter int VPN_W  = TLB_VPN_W,
  parameter int PID_W  = TLB_PID_W,
  parameter int PFN_W  = TLB_PFN_W,
  parameter int WP_BIT = TLB_WP_BIT,
  parameter int V_BIT  = TLB_V_BIT,
  localparam int IDX_W = idx_bits(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic              lk_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_frame,
  output logic              rsp_miss_exc,
  output logic              rsp_wprot_exc,
  output logic              rsp_multi,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_hi,
  input  logic [WORD_W-1:0] wr_lo,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_hi,
  output logic [WORD_W-1:0] rd_lo,
  input  logic              inval_all
);

  localparam int HI_VPN_LSB = WORD_W - VPN_W;
  localparam int HI_PID_LSB = HI_VPN_LSB - PID_W;
  localparam int LO_PFN_LSB = WORD_W - PFN_W;

  logic [SLOTS-1:0][VPN_W-1:0] vpn_q;
  logic [SLOTS-1:0][PID_W-1:0] pid_q;
  logic [SLOTS-1:0][PFN_W-1:0] pfn_q;
  logic [SLOTS-1:0]            wp_q;
  logic [SLOTS-1:0]            valid_q;
  logic [VPN_W-1:0]            rd_vpn;
  logic [PID_W-1:0]            rd_pid;
  logic [PFN_W-1:0]            rd_pfn;
  logic                        rd_wp;
  logic                        rd_valid;

  tlb_slot_store #(
    .SLOTS(SLOTS), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_vpn   (wr_hi[HI_VPN_LSB +: VPN_W]),
    .wr_pid   (wr_hi[HI_PID_LSB +: PID_W]),
    .wr_pfn   (wr_lo[LO_PFN_LSB +: PFN_W]),
    .wr_wp    (wr_lo[WP_BIT]),
    .wr_valid (wr_lo[V_BIT]),
    .inval_all(inval_all),
    .rd_idx   (rd_idx),
    .vpn_q    (vpn_q),
    .pid_q    (pid_q),
    .pfn_q    (pfn_q),
    .wp_q     (wp_q),
    .valid_q  (valid_q),
    .rd_vpn   (rd_vpn),
    .rd_pid   (rd_pid),
    .rd_pfn   (rd_pfn),
    .rd_wp    (rd_wp),
    .rd_valid (rd_valid)
  );

  logic             any_hit;
  logic             multi_hit;
  logic [PFN_W-1:0] hit_pfn;
  logic             hit_wp;

  tlb_match #(
    .SLOTS(SLOTS), .VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)
  ) u_match (
    .vpn_q    (vpn_q),
    .pid_q    (pid_q),
    .pfn_q    (pfn_q),
    .wp_q     (wp_q),
    .valid_q  (valid_q),
    .key_vpn  (lk_vpn),
    .key_pid  (lk_pid),
    .any_hit  (any_hit),
    .multi_hit(multi_hit),
    .hit_pfn  (hit_pfn),
    .hit_wp   (hit_wp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_frame     <= '0;
      rsp_miss_exc  <= 1'b0;
      rsp_wprot_exc <= 1'b0;
      rsp_multi     <= 1'b0;
    end else begin
      rsp_valid     <= lk_req;
      rsp_hit       <= lk_req && any_hit;
      rsp_frame     <= (lk_req && any_hit) ? hit_pfn : '0;
      rsp_miss_exc  <= lk_req && !any_hit;
      rsp_wprot_exc <= lk_req && any_hit && lk_write && !hit_wp;
      rsp_multi     <= lk_req && multi_hit;
    end
  end

  always_comb begin
    rd_hi = '0;
    rd_lo = '0;
    rd_hi[HI_VPN_LSB +: VPN_W] = rd_vpn;
    rd_hi[HI_PID_LSB +: PID_W] = rd_pid;
    rd_lo[LO_PFN_LSB +: PFN_W] = rd_pfn;
    rd_lo[WP_BIT]              = rd_wp;
    rd_lo[V_BIT]               = rd_valid;
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid && !rsp_hit && !rsp_miss_exc && !rsp_wprot_exc && !rsp_multi);

  // R4
  miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_miss_exc |-> !rsp_hit && (rsp_frame == '0));

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss_exc));

  // R5
  wprot_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_wprot_exc |-> rsp_hit);

  // R6
  multi_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> rsp_hit);

endmodule

// File: tb/tlb_sw_top_bench.sv
`timescale 1ns/1ps
module tlb_sw_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [5:0]  lk_pid = '0;
  logic        lk_write = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss_exc, rsp_wprot_exc, rsp_multi;
  logic [19:0] rsp_frame;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_hi = '0;
  logic [31:0] wr_lo = '0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_hi, rd_lo;
  logic        inval_all = 1'b0;

  always #2.5 clk = ~clk;

  tlb_sw_top u_tlb_sw_top (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_write(lk_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_frame(rsp_frame), .rsp_miss_exc(rsp_miss_exc),
    .rsp_wprot_exc(rsp_wprot_exc), .rsp_multi(rsp_multi), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_idx(rd_idx),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .inval_all(inval_all)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [19:0] m_vpn [64];
  logic [5:0]  m_pid [64];
  logic [19:0] m_pfn [64];
  bit          m_wp  [64];
  bit          m_v   [64];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hi(input logic [19:0] v, input logic [5:0] p);
    return {v, p, 6'b0};
  endfunction

  function automatic logic [31:0] mk_lo(input logic [19:0] f, input bit wp, input bit v);
    return {f, 1'b0, wp, v, 9'b0};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin
      m_vpn[i] = '0; m_pid[i] = '0; m_pfn[i] = '0; m_wp[i] = 0; m_v[i] = 0;
    end
  endtask

  task automatic do_write(input logic [5:0] idx, input logic [31:0] hi,
                          input logic [31:0] lo, input bit with_inval);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_hi = hi; wr_lo = lo; inval_all = with_inval;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; inval_all = 1'b0;
    if (with_inval) begin
      for (int i = 0; i < 64; i++) m_v[i] = 0;
    end else begin
      m_vpn[idx] = hi[31:12]; m_pid[idx] = hi[11:6];
      m_pfn[idx] = lo[31:12]; m_wp[idx] = lo[10]; m_v[idx] = lo[9];
    end
  endtask

  task automatic do_inval();
    @(negedge clk);
    inval_all = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inval_all = 1'b0;
    for (int i = 0; i < 64; i++) m_v[i] = 0;
  endtask

  task automatic do_probe(input logic [5:0] idx, input string req);
    @(negedge clk);
    rd_idx = idx;
    @(posedge clk);
    @(negedge clk);
    chk(req, {rd_hi, rd_lo}, {mk_hi(m_vpn[idx], m_pid[idx]),
                              mk_lo(m_pfn[idx], m_wp[idx], m_v[idx])});
  endtask

  task automatic do_lookup(input logic [19:0] v, input logic [5:0] p,
                           input bit w, input string tag);
    int first;
    int cnt;
    logic [24:0] exp;
    string req;
    first = -1; cnt = 0;
    for (int i = 0; i < 64; i++) begin
      if (m_v[i] && m_vpn[i] == v && m_pid[i] == p) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) begin
      exp = {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 20'h0};
      req = "R4";
    end else begin
      exp = {1'b1, 1'b1, 1'b0, (w && !m_wp[first]), (cnt > 1), m_pfn[first]};
      req = (cnt > 1) ? "R6" : ((w && !m_wp[first]) ? "R5" : "R3");
    end
    if (tag != "") req = tag;
    @(negedge clk);
    lk_req = 1'b1; lk_vpn = v; lk_pid = p; lk_write = w;
    @(posedge clk);
    @(negedge clk);
    lk_req = 1'b0;
    chk(req, {39'b0, rsp_valid, rsp_hit, rsp_miss_exc, rsp_wprot_exc, rsp_multi, rsp_frame},
        {39'b0, exp});
  endtask

  task automatic chk_idle(input string req);
    chk(req, {39'b0, rsp_valid, rsp_hit, rsp_miss_exc, rsp_wprot_exc, rsp_multi, rsp_frame}, 64'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    model_clear();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk_idle("R1");
    do_probe(6'd0, "R1");
    do_probe(6'd63, "R1");
    do_lookup(20'h0, 6'h0, 1'b0, "R1");

    // R2: field placement, unused bits dropped
    do_write(6'd5, mk_hi(20'h12345, 6'd7) | 32'h3F, mk_lo(20'hABCDE, 1, 1) | 32'h9FF, 1'b0);
    do_probe(6'd5, "R2");
    // R3: hit, identifier mismatch, page mismatch
    do_lookup(20'h12345, 6'd7, 1'b1, "R3");
    do_lookup(20'h12345, 6'd8, 1'b0, "R3");
    do_lookup(20'h12346, 6'd7, 1'b0, "R3");
    // R9: idle after a response
    @(negedge clk);
    chk_idle("R9");

    // R5: write protection, top slot
    do_write(6'd63, mk_hi(20'h00777, 6'd1), mk_lo(20'h00042, 0, 1), 1'b0);
    do_lookup(20'h00777, 6'd1, 1'b1, "R5");
    do_lookup(20'h00777, 6'd1, 1'b0, "R5");
    do_probe(6'd63, "R2");

    // R3: invalid slot ignored
    do_write(6'd10, mk_hi(20'h0BEEF, 6'd2), mk_lo(20'h11111, 1, 0), 1'b0);
    do_lookup(20'h0BEEF, 6'd2, 1'b0, "R3");

    // R6: duplicates, lowest index wins
    do_write(6'd40, mk_hi(20'h0CAFE, 6'd3), mk_lo(20'h44444, 1, 1), 1'b0);
    do_write(6'd20, mk_hi(20'h0CAFE, 6'd3), mk_lo(20'h22222, 1, 1), 1'b0);
    do_lookup(20'h0CAFE, 6'd3, 1'b0, "R6");

    // R10: rewrite replaces
    do_write(6'd20, mk_hi(20'h0D00D, 6'd3), mk_lo(20'h33333, 0, 1), 1'b0);
    do_lookup(20'h0CAFE, 6'd3, 1'b0, "R10");
    do_lookup(20'h0D00D, 6'd3, 1'b0, "R10");

    // R8: invalidate beats a same-cycle write
    do_write(6'd30, mk_hi(20'h05555, 6'd9), mk_lo(20'h66666, 1, 1), 1'b1);
    do_probe(6'd30, "R8");
    do_lookup(20'h05555, 6'd9, 1'b0, "R8");
    // R7: everything dropped, fields kept
    do_probe(6'd5, "R7");
    do_lookup(20'h12345, 6'd7, 1'b0, "R7");
    do_lookup(20'h0D00D, 6'd3, 1'b0, "R7");

    // Random phase
    for (int k = 0; k < 1500; k++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 35) begin
        logic [5:0] idx;
        logic [31:0] lo;
        idx = 6'($urandom_range(0, 63));
        lo = mk_lo(20'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0)) | (32'($urandom) & 32'h9FF);
        do_write(idx, mk_hi(20'($urandom_range(0, 7)), 6'($urandom_range(0, 3))) | (32'($urandom) & 32'h3F),
                 lo, ($urandom_range(0, 60) == 0));
      end else if (op < 37) begin
        do_inval();
      end else if (op < 47) begin
        do_probe(6'($urandom_range(0, 63)), "R2");
      end else begin
        do_lookup(20'($urandom_range(0, 7)), 6'($urandom_range(0, 3)), 1'($urandom), "");
        if ($urandom_range(0, 9) == 0) begin
          @(negedge clk);
          chk_idle("R9");
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule